// File: doc/BRIEF.md
# Streaming Corner-Turn Buffer

This block regroups a channelised sample stream. The input delivers all channels of one spectrum in a row, and the output delivers one channel across successive spectra. A frame holds IN_N × OUT_N words. The block stores it row by row into a matrix with IN_N columns and OUT_N rows, then reads it out column by column. Words move as whole units and their contents are never altered.

Two on-chip banks alternate. While one bank fills with the incoming frame, the other drains the previous frame in transposed order, so the output lags the input by exactly one frame. A new word arrives on every clock cycle. A one-cycle sync pulse marks the cycle before the first word of a frame on the input, and a matching pulse marks the cycle before the first reordered word on the output.

Both sizes are given as log2 values. The data width is a parameter with a default of 72 bits. A repeating input sync must recur at a whole multiple of IN_N·OUT_N cycles.

Top module: `corner_turn_buf`

## Requirements
- R1: Output word number `r + c·OUT_N` of a frame (row r in 0..OUT_N-1, column c in 0..IN_N-1) equals input word number `c + r·IN_N` of that frame.
- R2: Every output word is bit-identical to the input word it came from, so a constant field such as bits [71:64] = 0xA5 reaches every output word unchanged.
- R3: The word present in the cycle after `sync_in` is high is word 0 of a frame. Without a further sync, the following words continue the count and wrap to word 0 every IN_N·OUT_N cycles.
- R4: `sync_out` is high for exactly one cycle, the cycle just before the first reordered word of each completed frame, and low at all other times.
- R5: When word 0 of a frame enters in cycle c, output word j of that frame appears in cycle c + IN_N·OUT_N + j.
- R6: After reset and before the first `sync_in`, input words are ignored, and `dout_valid` and `sync_out` stay low.
- R7: `dout_valid` is high in cycles c+F through c+2F-1 (F = IN_N·OUT_N) for every frame that started in cycle c and was written completely, and low otherwise. Back-to-back frames therefore give an unbroken high `dout_valid`.
- R8: A `sync_in` pulse in the middle of a frame restarts the write count at word 0 of a new frame, and the partial frame is never output.
- R9: With IN_N = OUT_N = 4 and an input of 0..7 repeating, the first output frame is 0,4,0,4,1,5,1,5,2,6,2,6,3,7,3,7.
- R10: A low `rst_n` sampled on a rising edge clears the block, so `dout_valid` and `sync_out` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | High in the cycle before word 0 of an input frame |
| din | input | WIDTH | Input word, one per cycle |
| sync_out | output | 1 | High in the cycle before word 0 of a reordered frame |
| dout | output | WIDTH | Reordered output word |
| dout_valid | output | 1 | High while `dout` carries a word of a completed frame |

## Verification
Take a frame whose word 0 enters in cycle c. Its `sync_out` pulse is due in cycle c+F-1, and output word j is due in cycle c+F+j. A reset takes effect on the next edge. The bench keeps a cycle counter, logs every input word, and tracks frame starts and completions from its own stimulus. It samples the outputs on the falling edge of each cycle and compares them with the values predicted for that exact cycle. It runs two size pairs at once, 4×4 and 8 inputs × 2 outputs. Because both have a 16-word frame, the same stimulus and the same timing model cover both.

// File: rtl/ctb_pkg.sv
// Package: shared types and helpers for the corner-turn buffer.
// Assumes two banks only; bank identity is a one-bit enum.
package ctb_pkg;

    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    // Number of words in one frame for the given log2 sizes.
    function automatic int frame_words(input int log_in, input int log_out);
        return 1 << (log_in + log_out);
    endfunction

endpackage

// File: rtl/ctb_write_ctl.sv
// Write-side control: arms on the first sync, counts word positions in
// row order, flips the fill bank when a frame is complete, and raises a
// registered early sync one cycle before the first reordered word.
// Assumes a word on every cycle and IDX_W >= 1.
module ctb_write_ctl
    import ctb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic             armed,
    output logic [IDX_W-1:0] wr_idx,
    output bank_e            wr_bank,
    output logic             frame_done,
    output logic             sync_early
);

    localparam int               FRAME    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME - 1);
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(FRAME - 2);

    // The frame finishes on the cycle that writes the last position.
    assign frame_done = armed && (wr_idx == LAST_IDX);

    // Position counter, arm flag, fill bank and early sync register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            wr_idx     <= '0;
            wr_bank    <= BANK_0;
            sync_early <= 1'b0;
        end else begin
            if (sync_in) begin
                armed  <= 1'b1;
                wr_idx <= '0;
            end else if (armed) begin
                wr_idx <= wr_idx + 1'b1;
            end
            if (frame_done) begin
                wr_bank <= bank_e'(~wr_bank);
            end
            sync_early <= armed && (wr_idx == PRE_LAST) && !sync_in;
        end
    end

    // A sync always lands the counter on word 0 of an armed frame.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (armed && wr_idx == '0));

    // Without a sync, an armed counter steps by one each cycle.
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !sync_in) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

endmodule

// File: rtl/ctb_read_ctl.sv
// Read-side control: on a completed frame, starts draining the bank just
// filled, stepping the output count and swapping its row and column
// fields to form the column-order address.
// Assumes LOG_IN >= 1 and LOG_OUT >= 1, and frames no closer than one
// frame length apart.
module ctb_read_ctl
    import ctb_pkg::*;
#(
    parameter int LOG_IN  = 2,
    parameter int LOG_OUT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  bank_e                     start_bank,
    output logic                      rd_active,
    output logic [LOG_IN+LOG_OUT-1:0] rd_idx,
    output bank_e                     rd_bank,
    output logic [LOG_IN+LOG_OUT-1:0] rd_addr
);

    localparam int               IDX_W    = LOG_IN + LOG_OUT;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

    // Output count: low field is the row, high field is the column.
    // Storage address: low field is the column, high field is the row.
    assign rd_addr = {rd_idx[LOG_OUT-1:0], rd_idx[IDX_W-1:LOG_OUT]};

    // Drain sequencer: a new frame takes priority over running out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            rd_idx    <= '0;
            rd_bank   <= BANK_0;
        end else if (start) begin
            rd_active <= 1'b1;
            rd_idx    <= '0;
            rd_bank   <= start_bank;
        end else if (rd_active) begin
            rd_idx <= rd_idx + 1'b1;
            if (rd_idx == LAST_IDX) begin
                rd_active <= 1'b0;
            end
        end
    end

    // A drain in progress never stops before its last word.
    p_valid_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && rd_idx != LAST_IDX) |=> rd_active);

endmodule

// File: rtl/ctb_bank_ram.sv
// Two-bank word store: one write port that steers to the fill bank and
// one combinational read port that selects the drain bank.
// Storage is not reset; only words of written frames are ever read.
module ctb_bank_ram
    import ctb_pkg::*;
#(
    parameter int WIDTH = 72,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             we,
    input  bank_e            wbank,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  bank_e            rbank,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [WIDTH-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam bank_e MY_BANK = (b == 0) ? BANK_0 : BANK_1;
        logic [WIDTH-1:0] mem [DEPTH];

        // Store the incoming word when this bank is the fill bank.
        always_ff @(posedge clk) begin
            if (we && wbank == MY_BANK) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = mem[raddr];
    end

    assign rdata = (rbank == BANK_1) ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/corner_turn_buf.sv
// Streaming corner-turn buffer: writes each frame of IN_N x OUT_N words
// in row order into one bank while the other bank is read in column
// order. Latency is one frame; sync pulses lead data by one cycle.
// Assumes a word on every cycle and LOG_IN, LOG_OUT >= 1.
module corner_turn_buf
    import ctb_pkg::*;
#(
    parameter int WIDTH   = 72,
    parameter int LOG_IN  = 2,
    parameter int LOG_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [WIDTH-1:0] din,
    output logic             sync_out,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid
);

    localparam int IDX_W = LOG_IN + LOG_OUT;
    localparam int FRAME = frame_words(LOG_IN, LOG_OUT);

    logic             armed;
    logic [IDX_W-1:0] wr_idx;
    bank_e            wr_bank;
    logic             frame_done;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] rd_addr;
    bank_e            rd_bank;

    ctb_write_ctl #(.IDX_W(IDX_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .armed      (armed),
        .wr_idx     (wr_idx),
        .wr_bank    (wr_bank),
        .frame_done (frame_done),
        .sync_early (sync_out)
    );

    ctb_read_ctl #(.LOG_IN(LOG_IN), .LOG_OUT(LOG_OUT)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frame_done),
        .start_bank (wr_bank),
        .rd_active  (dout_valid),
        .rd_idx     (rd_idx),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr)
    );

    ctb_bank_ram #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (armed),
        .wbank (wr_bank),
        .waddr (wr_idx),
        .wdata (din),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (dout)
    );

    // Frame length must fit the index width chosen above.
    initial begin
        p_frame_size_r5: assert (FRAME == (1 << IDX_W) && LOG_IN >= 1 && LOG_OUT >= 1);
    end

    // The early sync is followed by word 0 of a draining frame.
    p_valid_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> (dout_valid && rd_idx == '0));

    // Nothing leaves the block before the first sync has armed it.
    p_unarmed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!dout_valid && !sync_out));

    // The bank being drained is never the bank being filled.
    p_bank_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (rd_bank != wr_bank));

endmodule

// File: tb/test_corner_turn_buf.sv
// Bench: drives a 4x4 and an 8x2 instance with one stimulus stream (both
// have 16-word frames) and checks every output cycle against a timing
// model built from its own stimulus, then walks the reference table.
module test_corner_turn_buf;

    localparam int W  = 72;
    localparam int F  = 16;
    localparam int NL = 2048;

    typedef struct packed {
        logic [7:0] stim;
        logic [7:0] expv;
    } vec_t;

    // Stimulus of one 4x4 frame and the expected first output frame (R9).
    localparam vec_t TBL [16] = '{
        '{8'd0, 8'd0}, '{8'd1, 8'd4}, '{8'd2, 8'd0}, '{8'd3, 8'd4},
        '{8'd4, 8'd1}, '{8'd5, 8'd5}, '{8'd6, 8'd1}, '{8'd7, 8'd5},
        '{8'd0, 8'd2}, '{8'd1, 8'd6}, '{8'd2, 8'd2}, '{8'd3, 8'd6},
        '{8'd4, 8'd3}, '{8'd5, 8'd7}, '{8'd6, 8'd3}, '{8'd7, 8'd7}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_in = 1'b0;
    logic [W-1:0] din = '0;
    logic         sync_a, sync_b, val_a, val_b;
    logic [W-1:0] dout_a, dout_b;

    logic [W-1:0] log_mem [NL];
    logic [7:0]   cap_a [NL];
    int           comp [256];
    int           ncomp = 0;
    int           cur_start = -1;
    int           cyc = 0;
    int           n_chk = 0;
    int           n_fail = 0;
    int           tbl_base = 0;
    bit           done = 1'b0;
    string        ptag = "R10";

    always #5 clk = ~clk;

    corner_turn_buf i_corner_turn_buf (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .din(din),
        .sync_out(sync_a), .dout(dout_a), .dout_valid(val_a)
    );

    corner_turn_buf #(.WIDTH(W), .LOG_IN(3), .LOG_OUT(1)) i_corner_turn_buf_wide (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .din(din),
        .sync_out(sync_b), .dout(dout_b), .dout_valid(val_b)
    );

    function automatic int in_pos(input int o, input int li, input int lo);
        int row = o % (1 << lo);
        int col = o / (1 << lo);
        return col + row * (1 << li);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // Compare one instance's outputs in cycle cyc with the model.
    task automatic check_inst(input logic v, input logic s, input logic [W-1:0] d,
                              input int li, input int lo, input string who);
        bit           ev = 1'b0;
        bit           es;
        logic [W-1:0] ed = '0;
        es = (cur_start >= 0) && (cyc == cur_start + F - 1);
        for (int k = ncomp - 1; k >= 0; k--) begin
            if (comp[k] + F <= cyc) begin
                ev = (cyc < comp[k] + 2 * F);
                if (ev) ed = log_mem[comp[k] + in_pos(cyc - comp[k] - F, li, lo)];
                break;
            end
        end
        chk(v === ev, {who, " valid R7 ", ptag}, W'(v), W'(ev));
        chk(s === es, {who, " sync_out R4 ", ptag}, W'(s), W'(es));
        if (ev) begin
            chk(d === ed, {who, " data R1 R5 ", ptag}, d, ed);
            if (ed[W-1 -: 8] == 8'hA5)
                chk(d[W-1 -: 8] === 8'hA5, {who, " field R2"}, W'(d[W-1 -: 8]), W'(8'hA5));
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive new inputs.
    task automatic step(input bit r, input bit s, input logic [W-1:0] d);
        @(negedge clk);
        cap_a[cyc] = dout_a[7:0];
        check_inst(val_a, sync_a, dout_a, 2, 2, "4x4");
        check_inst(val_b, sync_b, dout_b, 3, 1, "8x2");
        rst_n   = r;
        sync_in = s;
        din     = d;
        log_mem[cyc] = d;
        if (!r) begin
            cur_start = -1;
            ncomp     = 0;
        end else begin
            if (cur_start >= 0 && cyc == cur_start + F - 1) begin
                comp[ncomp] = cur_start;
                ncomp++;
                cur_start = cyc + 1;
            end
            if (s) cur_start = cyc + 1;
        end
        cyc++;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        // R10: reset state held with sync and data toggling.
        ptag = "R10";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, W'(i + 9));
        // R6: unarmed, data ignored.
        ptag = "R6";
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, W'(i * 3 + 1));
        // R3: sync arms; table stimulus with a sync before every frame.
        ptag = "R3";
        step(1'b1, 1'b1, W'(77));
        tbl_base = cyc;
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < F; i++)
                step(1'b1, i == F - 1, W'(TBL[i].stim));
        // R7 and R2: free-running frames, no further sync, constant top field.
        ptag = "R7";
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < F; i++)
                step(1'b1, 1'b0, {8'hA5, 64'(f * 1000 + i * 7 + 3)});
        // R8: sync in the middle of a frame, then regular frames and a drain.
        ptag = "R8";
        for (int i = 0; i < 6; i++) step(1'b1, i == 5, {8'hA5, 64'(500 + i)});
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < F; i++)
                step(1'b1, i == F - 1, {8'hA5, 64'(f * 100 + i + 9000)});
        for (int i = 0; i < 2 * F; i++) step(1'b1, 1'b0, {8'h3C, 64'(i)});
        // R10 then R6: reset mid-stream, then idle without sync.
        ptag = "R10";
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, W'(i));
        ptag = "R6";
        for (int i = 0; i < 2 * F + 4; i++) step(1'b1, 1'b0, W'(i + 40));
        // R9: walk the reference table against the first 4x4 output frame.
        for (int i = 0; i < 16; i++)
            chk(cap_a[tbl_base + F + i] === TBL[i].expv, "table R9",
                W'(cap_a[tbl_base + F + i]), W'(TBL[i].expv));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule